// File: doc/BRIEF.md
# Stop Mode Power Controller

This block sequences the deepest low-power state of a small microcontroller. Software requests the state by writing a stop request bit. If no interrupt is pending at that moment, the controller gates the CPU and peripheral clocks and turns off the oscillators that the current clock mode allows. It also either holds the external pins at their levels or floats them. Register and RAM contents are left untouched because only clocks are removed.

The block leaves the stopped state on one of two events. The first is a reset request. The second is an external interrupt whose 2-bit level code is a wake-capable priority. The CPU's own interrupt masking plays no part in wake-up. On either exit, both oscillators are enabled again and a parameterized stabilization count runs before the core clock and the pins are released. A one-cycle resume pulse and a flag giving the cause of exit then hand control back. The stop request bit clears itself at that point.

The counter is clocked by `clk`, which must come from a free-running wake-up time source that keeps running while the oscillators are stopped.

Top module: `stop_pwr_ctrl`

## Requirements
- R1: After power-on reset the block is running: main_osc_en, sub_osc_en and core_clk_en are 1, and pin_hiz, watch_irq_block, stop_bit, resume_pulse and cpu_rst_hold are 0.
- R2: A stop_wr sampled at a clock edge while irq_pending is 0 enters the stopped state at that edge. From the next cycle stop_bit is 1, core_clk_en is 0 and main_osc_en is 0.
- R3: A stop_wr sampled while irq_pending is 1 is discarded. The block stays running with stop_bit 0, and it does not enter the stopped state later when the pending flag drops.
- R4: While stopped, pin_hiz equals the value pin_hiz_sel had at the accepted stop write (1 floats the pins, 0 holds them). Later changes of pin_hiz_sel have no effect. pin_hiz keeps that value through the stabilization wait.
- R5: While stopped with sub_mode 0 (main clock mode), sub_osc_en stays 1 and watch_irq_block is 1. With sub_mode 1 (subclock mode), sub_osc_en is 0 as well. Both the sub_mode value and the pin select are captured at the accepted stop write.
- R6: Lane i of ext_irq_req wakes the stopped block only when its level field ext_irq_lvl[2i+1:2i] is 00, 01 or 10, where a smaller code means higher priority. Level 11 leaves the block stopped. External requests have no effect while running.
- R7: A rst_req sampled while stopped starts the stabilization wait. cpu_rst_hold is 1 for every cycle of that wait and falls when the wait ends.
- R8: The stabilization wait lasts exactly STAB_CYCLES cycles. During it both oscillator enables are 1, core_clk_en is 0 and watch_irq_block stays 1.
- R9: The wait is followed by exactly one cycle with resume_pulse 1, core_clk_en 1 and pin_hiz 0. In that cycle exit_by_reset is 1 for a reset exit and 0 for an interrupt exit. The block is then running again.
- R10: stop_bit reads 1 from the accepted write until the wait ends, and is 0 from the resume cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running wake-up time source clock |
| por_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| stop_wr | input | 1 | One-cycle write of 1 to the stop request bit |
| pin_hiz_sel | input | 1 | Pin-state select: 1 floats pins while stopped, 0 holds them |
| sub_mode | input | 1 | Clock mode: 0 main clock, 1 subclock |
| irq_pending | input | 1 | Some interrupt request is pending in the CPU |
| rst_req | input | 1 | Reset request observed while stopped |
| ext_irq_req | input | N_IRQ | External interrupt request lines |
| ext_irq_lvl | input | 2*N_IRQ | 2-bit level code per external line |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subclock oscillator enable |
| core_clk_en | output | 1 | CPU and peripheral clock gate enable |
| pin_hiz | output | 1 | Drives external pins to high impedance |
| watch_irq_block | output | 1 | Suppresses the watch interrupt |
| cpu_rst_hold | output | 1 | Holds the CPU in reset during a reset-caused wait |
| stop_bit | output | 1 | Read value of the stop request bit |
| resume_pulse | output | 1 | One-cycle pulse when execution resumes |
| exit_by_reset | output | 1 | Cause of the last exit: 1 reset, 0 interrupt |

## Verification
The embedded assertions check on every cycle that a rejected stop write keeps the block running, and that the block stays stopped with no wake event or reset present. They also check that the wait does not end before its counter expires, that the counter never exceeds its load value, that the resume pulse is one cycle wide, and that the stop bit falls only into the resume cycle. Other properties need whole scenarios and are shown only by the bench's sweeps. These are the exact wait length, which oscillators are kept under each clock mode, the capture of the pin select, and which of the four level codes wake the block on every external lane.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_STAB   = 2'd2,
    ST_RESUME = 2'd3
  } stop_state_t;

  // Smaller code = higher priority; the lowest priority cannot wake.
  localparam logic [1:0] LVL_NO_WAKE = 2'b11;

  function automatic logic lvl_wakes(input logic [1:0] lvl);
    return lvl != LVL_NO_WAKE;
  endfunction

endpackage

// File: rtl/stopctl_wake.sv
module stopctl_wake
  import stopctl_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0]   req,
  input  logic [2*N_IRQ-1:0] lvl,
  output logic               wake
);

  logic [N_IRQ-1:0] lane_hit;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_lane
    assign lane_hit[g] = req[g] && lvl_wakes(lvl[2*g +: 2]);
  end

  assign wake = |lane_hit;

endmodule

// File: rtl/stopctl_stab_cnt.sv
module stopctl_stab_cnt #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STAB_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt <= '0;
    else if (load)              cnt <= LOAD_VAL;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == CNT_W'(1));

  // R8: the counter never holds more than the programmed wait
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!por_n)
    cnt <= LOAD_VAL);

  // R8: expiry leaves the counter empty
  p_cnt_empty_after_done_r8: assert property (@(posedge clk) disable iff (!por_n)
    (done && !load) |=> cnt == '0);

endmodule

// File: rtl/stop_pwr_ctrl.sv
module stop_pwr_ctrl
  import stopctl_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int STAB_CYCLES = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               stop_wr,
  input  logic               pin_hiz_sel,
  input  logic               sub_mode,
  input  logic               irq_pending,
  input  logic               rst_req,
  input  logic [N_IRQ-1:0]   ext_irq_req,
  input  logic [2*N_IRQ-1:0] ext_irq_lvl,
  output logic               main_osc_en,
  output logic               sub_osc_en,
  output logic               core_clk_en,
  output logic               pin_hiz,
  output logic               watch_irq_block,
  output logic               cpu_rst_hold,
  output logic               stop_bit,
  output logic               resume_pulse,
  output logic               exit_by_reset
);

  stop_state_t st, st_nx;
  logic hiz_q, sub_q, reason_q, stop_q;

  // named internal events
  logic stop_accept, stop_reject, wake_hit, leave_stop, stab_done;

  stopctl_wake #(.N_IRQ(N_IRQ)) u_wake (
    .req  (ext_irq_req),
    .lvl  (ext_irq_lvl),
    .wake (wake_hit)
  );

  assign stop_accept = (st == ST_RUN) && stop_wr && !irq_pending;
  assign stop_reject = (st == ST_RUN) && stop_wr &&  irq_pending;
  assign leave_stop  = (st == ST_STOP) && (rst_req || wake_hit);

  stopctl_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk   (clk),
    .por_n (por_n),
    .load  (leave_stop),
    .run   (st == ST_STAB),
    .done  (stab_done)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RUN:    if (stop_accept) st_nx = ST_STOP;
      ST_STOP:   if (leave_stop)  st_nx = ST_STAB;
      ST_STAB:   if (stab_done)   st_nx = ST_RESUME;
      ST_RESUME: st_nx = ST_RUN;
      default:   st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= ST_RUN;
      hiz_q    <= 1'b0;
      sub_q    <= 1'b0;
      reason_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      st <= st_nx;
      if (stop_accept) begin
        hiz_q  <= pin_hiz_sel;
        sub_q  <= sub_mode;
        stop_q <= 1'b1;
      end
      if (leave_stop) reason_q <= rst_req;
      if (stab_done)  stop_q   <= 1'b0;
    end
  end

  always_comb begin
    main_osc_en     = 1'b1;
    sub_osc_en      = 1'b1;
    core_clk_en     = 1'b1;
    pin_hiz         = 1'b0;
    watch_irq_block = 1'b0;
    cpu_rst_hold    = 1'b0;
    resume_pulse    = 1'b0;
    unique case (st)
      ST_STOP: begin
        main_osc_en     = 1'b0;
        sub_osc_en      = !sub_q;
        core_clk_en     = 1'b0;
        pin_hiz         = hiz_q;
        watch_irq_block = 1'b1;
      end
      ST_STAB: begin
        core_clk_en     = 1'b0;
        pin_hiz         = hiz_q;
        watch_irq_block = 1'b1;
        cpu_rst_hold    = reason_q;
      end
      ST_RESUME: resume_pulse = 1'b1;
      default: ;
    endcase
  end

  assign stop_bit      = stop_q;
  assign exit_by_reset = reason_q;

  // R3: a stop write seen with an interrupt pending leaves the block running
  p_reject_stays_run_r3: assert property (@(posedge clk) disable iff (!por_n)
    stop_reject |=> (st == ST_RUN && !stop_q));

  // R6: external requests never move a running block except via a stop write
  p_run_ignores_ext_r6: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_RUN && !stop_accept) |=> st == ST_RUN);

  // R6: without a wake event or reset the block remains stopped
  p_stop_holds_r6: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_STOP && !rst_req && !wake_hit) |=> st == ST_STOP);

  // R8: the wait cannot end before the counter expires
  p_stab_holds_r8: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_STAB && !stab_done) |=> st == ST_STAB);

  // R9: resume is a single-cycle pulse followed by running
  p_resume_single_r9: assert property (@(posedge clk) disable iff (!por_n)
    resume_pulse |=> (!resume_pulse && st == ST_RUN));

  // R10: the stop bit self-clears exactly into the resume cycle
  p_stop_bit_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(stop_q) |-> st == ST_RESUME);

endmodule

// File: tb/test_stop_pwr_ctrl.sv
module test_stop_pwr_ctrl;

  localparam int  TB_IRQ  = 4;
  localparam int  TB_STAB = 7;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic stop_wr = 1'b0, pin_hiz_sel = 1'b0, sub_mode = 1'b0;
  logic irq_pending = 1'b0, rst_req = 1'b0;
  logic [TB_IRQ-1:0]   ext_irq_req = '0;
  logic [2*TB_IRQ-1:0] ext_irq_lvl = '1;
  logic main_osc_en, sub_osc_en, core_clk_en, pin_hiz, watch_irq_block;
  logic cpu_rst_hold, stop_bit, resume_pulse, exit_by_reset;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  stop_pwr_ctrl #(.N_IRQ(TB_IRQ), .STAB_CYCLES(TB_STAB)) i_stop_pwr_ctrl (
    .clk(clk), .por_n(por_n), .stop_wr(stop_wr), .pin_hiz_sel(pin_hiz_sel),
    .sub_mode(sub_mode), .irq_pending(irq_pending), .rst_req(rst_req),
    .ext_irq_req(ext_irq_req), .ext_irq_lvl(ext_irq_lvl),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .core_clk_en(core_clk_en),
    .pin_hiz(pin_hiz), .watch_irq_block(watch_irq_block), .cpu_rst_hold(cpu_rst_hold),
    .stop_bit(stop_bit), .resume_pulse(resume_pulse), .exit_by_reset(exit_by_reset)
  );

  // bench's own statement of which level codes wake
  function automatic bit tb_wakes(input int lv);
    return lv < 3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    por_n = 1'b1;
    step();
    // R1 reset state
    check("R1 main_osc_en", main_osc_en, 1);
    check("R1 sub_osc_en", sub_osc_en, 1);
    check("R1 core_clk_en", core_clk_en, 1);
    check("R1 pin_hiz", pin_hiz, 0);
    check("R1 watch_irq_block", watch_irq_block, 0);
    check("R1 stop_bit", stop_bit, 0);
    check("R1 resume_pulse", resume_pulse, 0);
    check("R1 cpu_rst_hold", cpu_rst_hold, 0);

    // R6: external requests while running do nothing
    ext_irq_req = '1;
    ext_irq_lvl = '0;
    step(); step();
    check("R6 run ext core_clk_en", core_clk_en, 1);
    check("R6 run ext main_osc_en", main_osc_en, 1);
    check("R6 run ext stop_bit", stop_bit, 0);
    ext_irq_req = '0;
    ext_irq_lvl = '1;

    // R3: write with interrupt pending is discarded, not deferred
    stop_wr = 1'b1; irq_pending = 1'b1;
    step();
    stop_wr = 1'b0; irq_pending = 1'b0;
    check("R3 stop_bit", stop_bit, 0);
    check("R3 core_clk_en", core_clk_en, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R3 later core_clk_en", core_clk_en, 1);
      check("R3 later main_osc_en", main_osc_en, 1);
    end

    // sweep: clock mode x pin select x lane x level
    for (int sm = 0; sm < 2; sm++)
      for (int hz = 0; hz < 2; hz++)
        for (int idx = 0; idx < TB_IRQ; idx++)
          for (int lv = 0; lv < 4; lv++) begin
            int n;
            bit exp_rst;
            stop_wr = 1'b1; pin_hiz_sel = hz[0]; sub_mode = sm[0];
            step();
            stop_wr = 1'b0; pin_hiz_sel = !hz[0]; sub_mode = !sm[0];
            check("R2 stop_bit", stop_bit, 1);
            check("R2 core_clk_en", core_clk_en, 0);
            check("R2 main_osc_en", main_osc_en, 0);
            check("R5 sub_osc_en", sub_osc_en, 1 - sm);
            check("R5 watch_irq_block", watch_irq_block, 1);
            check("R4 pin_hiz", pin_hiz, hz);
            ext_irq_req = '0;
            ext_irq_req[idx] = 1'b1;
            ext_irq_lvl = '1;
            ext_irq_lvl[2*idx +: 2] = 2'(lv);
            step();
            exp_rst = !tb_wakes(lv);
            if (exp_rst) begin
              check("R6 level 11 stays stopped", main_osc_en, 0);
              check("R6 level 11 core_clk_en", core_clk_en, 0);
              check("R4 pin_hiz held", pin_hiz, hz);
              ext_irq_req = '0;
              rst_req = 1'b1;
              step();
            end
            ext_irq_req = '0;
            rst_req = 1'b0;
            n = 0;
            while (!resume_pulse && n < 1000) begin
              check("R8 main_osc_en", main_osc_en, 1);
              check("R8 sub_osc_en", sub_osc_en, 1);
              check("R8 core_clk_en", core_clk_en, 0);
              check("R8 watch_irq_block", watch_irq_block, 1);
              check("R4 pin_hiz in wait", pin_hiz, hz);
              check("R7 cpu_rst_hold", cpu_rst_hold, int'(exp_rst));
              check("R10 stop_bit in wait", stop_bit, 1);
              n++;
              step();
            end
            check("R8 wait length", n, TB_STAB);
            check("R9 exit_by_reset", exit_by_reset, int'(exp_rst));
            check("R9 core_clk_en", core_clk_en, 1);
            check("R9 pin_hiz", pin_hiz, 0);
            check("R7 cpu_rst_hold released", cpu_rst_hold, 0);
            check("R10 stop_bit cleared", stop_bit, 0);
            step();
            check("R9 pulse width", resume_pulse, 0);
            check("R9 running core_clk_en", core_clk_en, 1);
            check("R9 running main_osc_en", main_osc_en, 1);
          end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule